// File: doc/BRIEF.md
# Fixed-Latency External Memory Sequencer

This block sits between a set of compute-side requesters and a 64-bit external memory port. The port has a 32-bit address output, a 64-bit write-data output, a 64-bit read-data input and separate read and write enables. Each requester presents a command (load, store or copy) with its own valid line. A fixed-priority arbiter picks one of them, and the sequencer then runs that command on the port with a fixed cycle pattern. A load presents its address for one cycle and takes the memory word seven cycles later. A store puts address and data on the port together in one cycle. A copy is a load whose last cycle becomes the write to the destination address. Completion is signalled by a one-cycle done pulse to the owner, and load data comes with that pulse. A command whose address lies outside the memory is refused with an error pulse and never reaches the port.

The most recent load result of every requester can be read by a host through a window of read-only slots. Slot i sits at `WIN_BASE + i*WIN_STRIDE`.

The sequencer has seven states. IDLE arbitrates. From there an accepted command goes to ADDR for a load or copy, to STORE for a store, or to FAULT for a refused command. ADDR always moves to WAIT. WAIT counts and leaves either to XFER, for a copy once its count reaches one less than the load latency, or to RESP, for a load once its count reaches the load latency. XFER and STORE both move to RESP. RESP and FAULT both return to IDLE.

Top module: `xmem_seq`

## Requirements
- R1: After reset, read enable, write enable, every grant, done and error output are low, and every host window slot reads zero.
- R2: In IDLE, the grant is one-hot and goes to the lowest-numbered requester whose valid is high. It is combinational and lasts only the acceptance cycle. Command codes: 2'b00 load, 2'b01 store, 2'b10 copy, 2'b11 illegal.
- R3: Load timing. Taking the grant cycle as cycle 0, the address is on the port with read enable high in cycle 1 only. The read data is sampled in cycle 8, which is seven cycles after the address cycle. Done for the owner and the load data on `rsp_rdata` appear in cycle 9.
- R4: Store timing. In cycle 1 the address, the write data and write enable are on the port together. Done appears in cycle 2, and read enable stays low.
- R5: Copy timing. The source address is on the port with read enable high in cycle 1. In cycle 8 the destination address is on the port, the read data is passed through to the write data, and write enable is high. Done appears in cycle 9. Read enable and write enable are never high in the same cycle.
- R6: Once a command is accepted, no further grant is issued until its done or error pulse has passed. Arbitration resumes in the cycle after that pulse.
- R7: A command is refused if its code is illegal, its address is at or above `MEM_WORDS`, or, for a copy, its destination is at or above `MEM_WORDS`. The owner gets an error pulse in cycle 1, no done pulse, and neither enable is raised.
- R8: A host address equal to `WIN_BASE + i*WIN_STRIDE` with i < NREQ gives hit high and the last load data returned to requester i. Any other address gives hit low and zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | NREQ | Command pending, one bit per requester |
| req_op | input | 2*NREQ | Command code per requester |
| req_addr | input | AW*NREQ | Address (source address for a copy) per requester |
| req_dst | input | AW*NREQ | Copy destination address per requester |
| req_wdata | input | DW*NREQ | Store data per requester |
| req_grant | output | NREQ | One-hot acceptance pulse |
| req_done | output | NREQ | Completion pulse for the owner |
| req_err | output | NREQ | Refusal pulse for the owner |
| rsp_rdata | output | DW | Most recent load data, valid with done |
| mem_mar | output | AW | Memory address |
| mem_mdr_out | output | DW | Memory write data |
| mem_mdr_in | input | DW | Memory read data |
| mem_ren | output | 1 | Memory read enable |
| mem_wen | output | 1 | Memory write enable |
| host_addr | input | AW | Host window read address |
| host_hit | output | 1 | Host address matches a slot |
| host_rdata | output | DW | Host window read data |

## Verification
The bench builds the block with NREQ = 3 and MEM_WORDS = 256, and keeps the default window base and stride. With that memory size the bench's memory model covers every legal address, so address 255 works as the last legal word and 256 as the first refused one. With three requesters, two slots can be active while a third stays idle, which exercises both the priority order and the grant hold. The window spacing is unchanged, so the bench can also probe a half-stride miss and the slot position just past the last requester.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_COPY  = 2'b10,
        OP_BAD   = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_WAIT,
        S_XFER,
        S_STORE,
        S_RESP,
        S_FAULT
    } state_e;

endpackage

// File: rtl/xmem_arb.sv
module xmem_arb #(
    parameter int NREQ = 4,
    localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [NREQ-1:0] valid,
    output logic [NREQ-1:0] grant,
    output logic [IW-1:0]   idx
);

    logic [NREQ:0] seen;

    assign seen[0] = 1'b0;

    genvar gi;
    generate
        for (gi = 0; gi < NREQ; gi++) begin : g_slot
            assign grant[gi]    = en & valid[gi] & ~seen[gi];
            assign seen[gi + 1] = seen[gi] | valid[gi];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (grant[i]) idx = IW'(i);
        end
    end

    // R2: at most one grant at a time
    p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2: nobody below the granted index is waiting
    p_grant_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> (((grant - NREQ'(1)) & valid) == '0));

    // R2: a grant only goes to a requester that asks
    p_grant_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~valid) == '0));

endmodule

// File: rtl/xmem_fsm.sv
module xmem_fsm
    import xmem_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 64,
    parameter int IW        = 2,
    parameter int MEM_WORDS = 1000000,
    parameter int LOAD_LAT  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    start_op,
    input  logic [AW-1:0] start_src,
    input  logic [AW-1:0] start_dst,
    input  logic [DW-1:0] start_wdata,
    input  logic [IW-1:0] start_id,
    input  logic [DW-1:0] mem_mdr_in,
    output logic          idle,
    output logic [AW-1:0] mem_mar,
    output logic [DW-1:0] mem_mdr_out,
    output logic          mem_ren,
    output logic          mem_wen,
    output logic          resp_done,
    output logic          resp_err,
    output logic          resp_load,
    output logic [IW-1:0] resp_id,
    output logic [DW-1:0] ld_data
);

    localparam int            CW       = $clog2(LOAD_LAT + 1);
    localparam logic [CW-1:0] LAT_END  = CW'(LOAD_LAT);
    localparam logic [CW-1:0] COPY_END = CW'(LOAD_LAT - 1);
    localparam logic [AW:0]   LIMIT    = (AW + 1)'(MEM_WORDS);

    state_e        state_q, state_d;
    op_e           op_q;
    logic [AW-1:0] src_q, dst_q;
    logic [DW-1:0] wd_q, ld_q;
    logic [IW-1:0] id_q;
    logic [CW-1:0] cnt_q;

    logic src_bad, dst_bad, bad_cmd;

    assign src_bad = {1'b0, start_src} >= LIMIT;
    assign dst_bad = {1'b0, start_dst} >= LIMIT;
    assign bad_cmd = (start_op == OP_BAD) || src_bad
                     || ((start_op == OP_COPY) && dst_bad);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (bad_cmd)                    state_d = S_FAULT;
                    else if (start_op == OP_STORE)  state_d = S_STORE;
                    else                            state_d = S_ADDR;
                end
            end
            S_ADDR:  state_d = S_WAIT;
            S_WAIT: begin
                if (op_q == OP_COPY && cnt_q == COPY_END)     state_d = S_XFER;
                else if (op_q == OP_LOAD && cnt_q == LAT_END) state_d = S_RESP;
            end
            S_XFER:  state_d = S_RESP;
            S_STORE: state_d = S_RESP;
            S_RESP:  state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // command capture, cycle counter, load data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_LOAD;
            src_q <= '0;
            dst_q <= '0;
            wd_q  <= '0;
            id_q  <= '0;
            cnt_q <= '0;
            ld_q  <= '0;
        end else begin
            if (state_q == S_IDLE && start) begin
                op_q  <= op_e'(start_op);
                src_q <= start_src;
                dst_q <= start_dst;
                wd_q  <= start_wdata;
                id_q  <= start_id;
            end
            if (state_q == S_ADDR)      cnt_q <= CW'(1);
            else if (state_q == S_WAIT) cnt_q <= cnt_q + CW'(1);
            if (state_q == S_WAIT && op_q == OP_LOAD && cnt_q == LAT_END)
                ld_q <= mem_mdr_in;
        end
    end

    // outputs
    always_comb begin
        idle        = 1'b0;
        mem_mar     = '0;
        mem_mdr_out = '0;
        mem_ren     = 1'b0;
        mem_wen     = 1'b0;
        resp_done   = 1'b0;
        resp_err    = 1'b0;
        unique case (state_q)
            S_IDLE:  idle = 1'b1;
            S_ADDR: begin
                mem_mar = src_q;
                mem_ren = 1'b1;
            end
            S_WAIT:  ;
            S_XFER: begin
                mem_mar     = dst_q;
                mem_mdr_out = mem_mdr_in;
                mem_wen     = 1'b1;
            end
            S_STORE: begin
                mem_mar     = src_q;
                mem_mdr_out = wd_q;
                mem_wen     = 1'b1;
            end
            S_RESP:  resp_done = 1'b1;
            S_FAULT: resp_err  = 1'b1;
            default: ;
        endcase
    end

    assign resp_load = (op_q == OP_LOAD);
    assign resp_id   = id_q;
    assign ld_data   = ld_q;

    // checker: cycles since the last read enable, saturating
    logic [CW:0] since_ren;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           since_ren <= '0;
        else if (mem_ren)                     since_ren <= (CW + 1)'(1);
        else if (since_ren != '1 && since_ren != '0) since_ren <= since_ren + (CW + 1)'(1);
    end

    // R5: the two enables never overlap
    p_no_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_ren && mem_wen));

    // R3: read enable lasts a single cycle
    p_ren_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ren |=> !mem_ren);

    // R3: load done comes LOAD_LAT+1 cycles after the address cycle
    p_load_lat_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && resp_load) |-> (since_ren == (CW + 1)'(LOAD_LAT + 1)));

    // R5: copy write lands LOAD_LAT cycles after its read address
    p_copy_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen && state_q == S_XFER) |-> (since_ren == (CW + 1)'(LOAD_LAT)));

    // R7: the port never carries an out-of-range write
    p_wen_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wen |-> ({1'b0, mem_mar} < LIMIT));

    // R7: a refusal leaves the port quiet
    p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_err |-> (!mem_ren && !mem_wen && $past(!mem_ren && !mem_wen)));

endmodule

// File: rtl/xmem_win.sv
module xmem_win #(
    parameter int NREQ       = 4,
    parameter int AW         = 32,
    parameter int DW         = 64,
    parameter int WIN_BASE   = 32'h1000,
    parameter int WIN_STRIDE = 32'h200,
    localparam int IW        = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_id,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_hit,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0]   slot_q [NREQ];
    logic [NREQ-1:0] slot_hit;

    genvar gi;
    generate
        for (gi = 0; gi < NREQ; gi++) begin : g_slot
            localparam logic [AW-1:0] SLOT_ADDR = AW'(WIN_BASE + gi * WIN_STRIDE);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                           slot_q[gi] <= '0;
                else if (wr_en && wr_id == IW'(gi))   slot_q[gi] <= wr_data;
            end

            assign slot_hit[gi] = (rd_addr == SLOT_ADDR);
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (slot_hit[i]) rd_data = rd_data | slot_q[i];
        end
    end

    assign rd_hit = |slot_hit;

endmodule

// File: rtl/xmem_seq.sv
module xmem_seq
    import xmem_pkg::*;
#(
    parameter int NREQ       = 4,
    parameter int AW         = 32,
    parameter int DW         = 64,
    parameter int MEM_WORDS  = 1000000,
    parameter int LOAD_LAT   = 7,
    parameter int WIN_BASE   = 32'h1000,
    parameter int WIN_STRIDE = 32'h200
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREQ-1:0]    req_valid,
    input  logic [2*NREQ-1:0]  req_op,
    input  logic [AW*NREQ-1:0] req_addr,
    input  logic [AW*NREQ-1:0] req_dst,
    input  logic [DW*NREQ-1:0] req_wdata,
    output logic [NREQ-1:0]    req_grant,
    output logic [NREQ-1:0]    req_done,
    output logic [NREQ-1:0]    req_err,
    output logic [DW-1:0]      rsp_rdata,
    output logic [AW-1:0]      mem_mar,
    output logic [DW-1:0]      mem_mdr_out,
    input  logic [DW-1:0]      mem_mdr_in,
    output logic               mem_ren,
    output logic               mem_wen,
    input  logic [AW-1:0]      host_addr,
    output logic               host_hit,
    output logic [DW-1:0]      host_rdata
);

    localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

    logic          idle;
    logic [IW-1:0] sel_idx;
    logic          resp_done, resp_err, resp_load;
    logic [IW-1:0] resp_id;
    logic [DW-1:0] ld_data;

    xmem_arb #(.NREQ(NREQ)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (idle),
        .valid (req_valid),
        .grant (req_grant),
        .idx   (sel_idx)
    );

    xmem_fsm #(
        .AW        (AW),
        .DW        (DW),
        .IW        (IW),
        .MEM_WORDS (MEM_WORDS),
        .LOAD_LAT  (LOAD_LAT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (|req_grant),
        .start_op    (req_op[32'(sel_idx) * 2 +: 2]),
        .start_src   (req_addr[32'(sel_idx) * AW +: AW]),
        .start_dst   (req_dst[32'(sel_idx) * AW +: AW]),
        .start_wdata (req_wdata[32'(sel_idx) * DW +: DW]),
        .start_id    (sel_idx),
        .mem_mdr_in  (mem_mdr_in),
        .idle        (idle),
        .mem_mar     (mem_mar),
        .mem_mdr_out (mem_mdr_out),
        .mem_ren     (mem_ren),
        .mem_wen     (mem_wen),
        .resp_done   (resp_done),
        .resp_err    (resp_err),
        .resp_load   (resp_load),
        .resp_id     (resp_id),
        .ld_data     (ld_data)
    );

    xmem_win #(
        .NREQ       (NREQ),
        .AW         (AW),
        .DW         (DW),
        .WIN_BASE   (WIN_BASE),
        .WIN_STRIDE (WIN_STRIDE)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (resp_done && resp_load),
        .wr_id   (resp_id),
        .wr_data (ld_data),
        .rd_addr (host_addr),
        .rd_hit  (host_hit),
        .rd_data (host_rdata)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NREQ; gi++) begin : g_resp
            assign req_done[gi] = resp_done && (resp_id == IW'(gi));
            assign req_err[gi]  = resp_err  && (resp_id == IW'(gi));
        end
    endgenerate

    assign rsp_rdata = ld_data;

    // R6: an accepted command is never followed by a grant in the next cycle
    p_no_regrant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_grant) |=> (req_grant == '0));

    // R6: no grant in a cycle that carries a done or error pulse
    p_no_grant_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|req_done) || (|req_err)) |-> (req_grant == '0));

    // R7: done and error never go out together
    p_done_xor_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !((|req_done) && (|req_err)));

endmodule

// File: tb/xmem_seq_tb.sv
`timescale 1ns/1ps
module xmem_seq_tb;

    localparam int NREQ   = 3;
    localparam int AW     = 32;
    localparam int DW     = 64;
    localparam int MEMW   = 256;
    localparam int BASE   = 32'h1000;
    localparam int STRIDE = 32'h200;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NREQ-1:0]    req_valid = '0;
    logic [2*NREQ-1:0]  req_op = '0;
    logic [AW*NREQ-1:0] req_addr = '0;
    logic [AW*NREQ-1:0] req_dst = '0;
    logic [DW*NREQ-1:0] req_wdata = '0;
    logic [NREQ-1:0]    req_grant, req_done, req_err;
    logic [DW-1:0]      rsp_rdata;
    logic [AW-1:0]      mem_mar;
    logic [DW-1:0]      mem_mdr_out, mem_mdr_in;
    logic               mem_ren, mem_wen;
    logic [AW-1:0]      host_addr = '0;
    logic               host_hit;
    logic [DW-1:0]      host_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    xmem_seq #(
        .NREQ       (NREQ),
        .AW         (AW),
        .DW         (DW),
        .MEM_WORDS  (MEMW),
        .LOAD_LAT   (7),
        .WIN_BASE   (BASE),
        .WIN_STRIDE (STRIDE)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_op      (req_op),
        .req_addr    (req_addr),
        .req_dst     (req_dst),
        .req_wdata   (req_wdata),
        .req_grant   (req_grant),
        .req_done    (req_done),
        .req_err     (req_err),
        .rsp_rdata   (rsp_rdata),
        .mem_mar     (mem_mar),
        .mem_mdr_out (mem_mdr_out),
        .mem_mdr_in  (mem_mdr_in),
        .mem_ren     (mem_ren),
        .mem_wen     (mem_wen),
        .host_addr   (host_addr),
        .host_hit    (host_hit),
        .host_rdata  (host_rdata)
    );

    // memory model: data for a read appears seven cycles after its address cycle
    logic [63:0] bmem [0:255];
    logic [7:0]  pa [0:6];
    logic        pv [0:6];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 256; k++) bmem[k] <= {32'hC0DE0000 | 32'(k), 32'(k * 7 + 1)};
            for (int k = 0; k < 7; k++) begin
                pv[k] <= 1'b0;
                pa[k] <= '0;
            end
        end else begin
            pv[0] <= mem_ren;
            pa[0] <= mem_mar[7:0];
            for (int k = 1; k < 7; k++) begin
                pv[k] <= pv[k-1];
                pa[k] <= pa[k-1];
            end
            if (mem_wen && mem_mar < 32'(MEMW)) bmem[mem_mar[7:0]] <= mem_mdr_out;
        end
    end

    assign mem_mdr_in = pv[6] ? bmem[pa[6]] : 64'h0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input int id, input logic [1:0] op, input logic [31:0] a,
                          input logic [31:0] d, input logic [63:0] w,
                          output int lat, output logic e, output int rn, output int wn,
                          output int rat, output int wat, output logic [31:0] wmar,
                          output logic [63:0] rd);
        int guard;
        @(negedge clk);
        req_op[id*2 +: 2]     = op;
        req_addr[id*AW +: AW] = a;
        req_dst[id*AW +: AW]  = d;
        req_wdata[id*DW +: DW] = w;
        req_valid[id]         = 1'b1;
        #1;
        guard = 0;
        while (!req_grant[id] && guard < 50) begin
            @(negedge clk);
            #1;
            guard++;
        end
        lat = 0; e = 1'b0; rn = 0; wn = 0; rat = -1; wat = -1; wmar = '0; rd = '0;
        @(negedge clk);
        req_valid[id] = 1'b0;
        lat = 1;
        while (1) begin
            if (mem_ren) begin rn++; rat = lat; end
            if (mem_wen) begin wn++; wat = lat; wmar = mem_mar; end
            if (req_done[id] || req_err[id]) begin
                e  = req_err[id];
                rd = rsp_rdata;
                break;
            end
            if (lat > 40) break;
            @(negedge clk);
            lat++;
        end
    endtask

    typedef struct packed {
        logic [1:0]  id;
        logic [1:0]  op;
        logic [31:0] a;
        logic [31:0] d;
        logic [63:0] w;
        logic        xerr;
    } vec_t;

    localparam vec_t TBL [10] = '{
        '{2'd0, 2'b00, 32'd5,   32'd0,   64'd0,                  1'b0},
        '{2'd1, 2'b01, 32'd9,   32'd0,   64'h1122334455667788,   1'b0},
        '{2'd2, 2'b00, 32'd9,   32'd0,   64'd0,                  1'b0},
        '{2'd1, 2'b10, 32'd9,   32'd20,  64'd0,                  1'b0},
        '{2'd0, 2'b00, 32'd20,  32'd0,   64'd0,                  1'b0},
        '{2'd2, 2'b00, 32'd255, 32'd0,   64'd0,                  1'b0},
        '{2'd1, 2'b00, 32'd256, 32'd0,   64'd0,                  1'b1},
        '{2'd0, 2'b10, 32'd3,   32'd256, 64'd0,                  1'b1},
        '{2'd2, 2'b01, 32'd300, 32'd0,   64'hFFFF,               1'b1},
        '{2'd0, 2'b11, 32'd4,   32'd0,   64'd0,                  1'b1}
    };

    initial begin
        int lat, rn, wn, rat, wat;
        logic e;
        logic [31:0] wmar;
        logic [63:0] rd, snap;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        host_addr = 32'(BASE);
        #1;
        chk(!mem_ren && !mem_wen, "R1 enables low", {62'd0, mem_ren, mem_wen}, 64'd0);
        chk(req_grant == '0 && req_done == '0 && req_err == '0, "R1 no grant/done/err",
            {55'd0, req_grant, req_done, req_err}, 64'd0);
        chk(host_hit == 1'b1 && host_rdata == '0, "R1 window slot cleared", host_rdata, 64'd0);

        // table walk: R3 R4 R5 R7 R8
        for (int i = 0; i < 10; i++) begin
            snap = (TBL[i].a < 32'(MEMW)) ? bmem[TBL[i].a[7:0]] : 64'd0;
            run_op(int'(TBL[i].id), TBL[i].op, TBL[i].a, TBL[i].d, TBL[i].w,
                   lat, e, rn, wn, rat, wat, wmar, rd);
            chk(e == TBL[i].xerr, "R7 error flag", {63'd0, e}, {63'd0, TBL[i].xerr});
            if (TBL[i].xerr) begin
                chk(lat == 1, "R7 error in cycle 1", 64'(lat), 64'd1);
                chk(rn == 0 && wn == 0, "R7 no enable on refusal", 64'(rn + wn), 64'd0);
            end else begin
                case (TBL[i].op)
                    2'b00: begin
                        chk(lat == 9, "R3 load done cycle", 64'(lat), 64'd9);
                        chk(rn == 1 && rat == 1 && wn == 0, "R3 single read enable in cycle 1",
                            64'(rat), 64'd1);
                        chk(rd == snap, "R3 load data", rd, snap);
                        @(negedge clk);
                        host_addr = 32'(BASE) + 32'(TBL[i].id) * 32'(STRIDE);
                        #1;
                        chk(host_hit && host_rdata == snap, "R8 window slot data", host_rdata, snap);
                    end
                    2'b01: begin
                        chk(lat == 2, "R4 store done cycle", 64'(lat), 64'd2);
                        chk(wn == 1 && wat == 1 && rn == 0, "R4 write enable in cycle 1",
                            64'(wat), 64'd1);
                        chk(wmar == TBL[i].a, "R4 store address", 64'(wmar), 64'(TBL[i].a));
                        chk(bmem[TBL[i].a[7:0]] == TBL[i].w, "R4 stored data",
                            bmem[TBL[i].a[7:0]], TBL[i].w);
                    end
                    default: begin
                        chk(lat == 9, "R5 copy done cycle", 64'(lat), 64'd9);
                        chk(rn == 1 && rat == 1, "R5 copy read in cycle 1", 64'(rat), 64'd1);
                        chk(wn == 1 && wat == 8, "R5 copy write in cycle 8", 64'(wat), 64'd8);
                        chk(wmar == TBL[i].d, "R5 copy destination", 64'(wmar), 64'(TBL[i].d));
                        chk(bmem[TBL[i].d[7:0]] == snap, "R5 copied data",
                            bmem[TBL[i].d[7:0]], snap);
                    end
                endcase
            end
        end

        // R2 and R6: simultaneous requests, priority and hold
        @(negedge clk);
        req_op[1*2 +: 2]     = 2'b00;
        req_addr[1*AW +: AW] = 32'd1;
        req_op[2*2 +: 2]     = 2'b00;
        req_addr[2*AW +: AW] = 32'd2;
        req_valid[1] = 1'b1;
        req_valid[2] = 1'b1;
        #1;
        chk(req_grant == 3'b010, "R2 lowest index wins", 64'(req_grant), 64'd2);
        @(negedge clk);
        req_valid[1] = 1'b0;
        for (int k = 1; k <= 9; k++) begin
            if (k > 1) @(negedge clk);
            #1;
            chk(req_grant == '0, "R6 no grant while busy", 64'(req_grant), 64'd0);
        end
        chk(req_done == 3'b010, "R3 done to owner", 64'(req_done), 64'd2);
        chk(rsp_rdata == bmem[1], "R3 priority load data", rsp_rdata, bmem[1]);
        @(negedge clk);
        #1;
        chk(req_grant == 3'b100, "R6 rearbitration after done", 64'(req_grant), 64'd4);
        @(negedge clk);
        req_valid[2] = 1'b0;
        for (int k = 0; k < 20; k++) begin
            if (req_done[2]) break;
            @(negedge clk);
        end
        chk(req_done[2] && rsp_rdata == bmem[2], "R3 second load data", rsp_rdata, bmem[2]);

        // R8: window misses
        host_addr = 32'(BASE) + 32'h100;
        #1;
        chk(!host_hit && host_rdata == '0, "R8 half-stride miss", host_rdata, 64'd0);
        host_addr = 32'(BASE) + 32'd3 * 32'(STRIDE);
        #1;
        chk(!host_hit && host_rdata == '0, "R8 slot past last requester", host_rdata, 64'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R6 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule